// File: doc/BRIEF.md
# Staircase Back-off Period Calculator

This block works out how long a core stays clock-gated after one of its transactions is aborted. It takes two saturating 8-bit event counts: the number of aborts the current transaction has suffered, and the number of times the gating window has been renewed at that abort level. It also takes a programmable base constant. Each count is rounded up to the next power of two, the two rounded values are added, and the sum is multiplied by the base. The result is a step function. It changes only when a count crosses a power-of-two boundary, so the steps get wider as the counts grow.

A gating controller raises a one-cycle request with the counts and base on its inputs. One cycle later the block returns the period on a registered output, together with a one-cycle valid pulse. The controller loads this value into its countdown timer. The period is held until the next request. Firmware normally sets the base to 8.

Top module: `backoff_period_calc`

## Requirements
- R1: `done_o` is high in the cycle after each cycle in which `start_i` is high, and low in every other cycle.
- R2: A count of 0 adds 0 to the sum, so both counts at 0 give a period of 0.
- R3: A count of 1 adds 1 to the sum, so one count at 1 and the other at 0 gives a period equal to the base.
- R4: A count N of 2 or more adds the smallest power of two that is not below N (for example 4 adds 4, 5 adds 8, 17 adds 32).
- R5: `period_o` equals the base multiplied by the sum of the abort-count term and the renew-count term, for every pair of counts and every base value.
- R6: `period_o` keeps its value in every cycle in which `start_i` is low.
- R7: The counts and the base are taken only in a cycle where `start_i` is high. Changes to them in other cycles have no effect on `period_o`.
- R8: With both counts at 255 and the base at 65535, `period_o` is 65535 × 512 with no truncation. The output width is base width + count width + 2 bits.
- R9: After reset, `done_o` is 0 and `period_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; samples the counts and the base |
| abort_cnt_i | input | 8 | Saturating abort count |
| renew_cnt_i | input | 8 | Saturating renew count |
| base_i | input | 16 | Programmable base constant |
| period_o | output | 26 | Registered gating period |
| done_o | output | 1 | One-cycle pulse when `period_o` is updated |

## Verification
The bench builds two copies of the block with the default 8-bit counts and 16-bit base. The first copy uses the leading-one exponent encoder and the shift-add scaler. The second uses the threshold-ladder encoder and the plain multiplier. Because the counts are only 8 bits wide, the bench can issue all 65,536 count pairs back to back at base 8, which walks every staircase boundary of both terms in both variants. A set of directed requests then covers the extreme base values, the hold behaviour between requests and the input changes that must be ignored.

// File: rtl/bopc_pkg.sv
package bopc_pkg;

   // How a count is turned into its power-of-two term.
   typedef enum logic [0:0] {
      TERM_PRIO   = 1'b0,   // leading one of (N-1), plus one
      TERM_LADDER = 1'b1    // smallest threshold 2^k that is not below N
   } term_style_e;

   // How the base is scaled by the summed terms.
   typedef enum logic [0:0] {
      SCALE_SHIFT = 1'b0,   // shift-add over the bits of the sum
      SCALE_MULT  = 1'b1    // a single multiply
   } scale_style_e;

endpackage

// File: rtl/bopc_term.sv
module bopc_term
   import bopc_pkg::*;
#(
   parameter int          CNT_W = 8,
   parameter term_style_e STYLE = TERM_PRIO
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W:0]   term_o
);

   localparam int EXP_W = $clog2(CNT_W + 1);

   logic             nz;
   logic [EXP_W-1:0] expo;

   assign nz = |cnt_i;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("bopc_term: CNT_W must be at least 1");
      end

      if (STYLE == TERM_PRIO) begin : g_prio
         logic [CNT_W-1:0] dec;
         assign dec = cnt_i - CNT_W'(1);
         always_comb begin
            expo = '0;
            for (int i = 0; i < CNT_W; i++) begin
               if (dec[i]) expo = EXP_W'(i + 1);
            end
         end
      end else begin : g_ladder
         always_comb begin
            expo = '0;
            for (int k = CNT_W; k >= 0; k--) begin
               if ({1'b0, cnt_i} <= ((CNT_W+1)'(1) << k)) expo = EXP_W'(k);
            end
         end
      end
   endgenerate

   assign term_o = nz ? ((CNT_W+1)'(1) << expo) : '0;

endmodule

// File: rtl/bopc_scale.sv
module bopc_scale
   import bopc_pkg::*;
#(
   parameter int           BASE_W = 16,
   parameter int           SUM_W  = 10,
   parameter scale_style_e STYLE  = SCALE_SHIFT,
   localparam int          OUT_W  = BASE_W + SUM_W
) (
   input  logic [BASE_W-1:0] base_i,
   input  logic [SUM_W-1:0]  sum_i,
   output logic [OUT_W-1:0]  prod_o
);

   generate
      if (BASE_W < 1 || SUM_W < 2) begin : g_bad_width
         $error("bopc_scale: widths too small");
      end

      if (STYLE == SCALE_SHIFT) begin : g_shift
         logic [OUT_W-1:0] part [SUM_W];
         for (genvar i = 0; i < SUM_W; i++) begin : g_part
            assign part[i] = sum_i[i] ? (OUT_W'(base_i) << i) : '0;
         end
         always_comb begin
            prod_o = '0;
            for (int i = 0; i < SUM_W; i++) prod_o = prod_o + part[i];
         end
      end else begin : g_mult
         assign prod_o = OUT_W'(base_i) * OUT_W'(sum_i);
      end
   endgenerate

endmodule

// File: rtl/backoff_period_calc.sv
module backoff_period_calc
   import bopc_pkg::*;
#(
   parameter int           CNT_W       = 8,
   parameter int           BASE_W      = 16,
   parameter term_style_e  TERM_STYLE  = TERM_PRIO,
   parameter scale_style_e SCALE_STYLE = SCALE_SHIFT,
   localparam int          SUM_W       = CNT_W + 2,
   localparam int          OUT_W       = BASE_W + SUM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  abort_cnt_i,
   input  logic [CNT_W-1:0]  renew_cnt_i,
   input  logic [BASE_W-1:0] base_i,
   output logic [OUT_W-1:0]  period_o,
   output logic              done_o
);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("backoff_period_calc: CNT_W out of range");
      end
      if (BASE_W < 1 || BASE_W > 32) begin : g_bad_base
         $error("backoff_period_calc: BASE_W out of range");
      end
   endgenerate

   logic [CNT_W:0]    term_abort;
   logic [CNT_W:0]    term_renew;
   logic [SUM_W-1:0]  term_sum;
   logic [OUT_W-1:0]  prod;

   bopc_term #(.CNT_W(CNT_W), .STYLE(TERM_STYLE)) u_term_abort (
      .cnt_i  (abort_cnt_i),
      .term_o (term_abort)
   );

   bopc_term #(.CNT_W(CNT_W), .STYLE(TERM_STYLE)) u_term_renew (
      .cnt_i  (renew_cnt_i),
      .term_o (term_renew)
   );

   assign term_sum = SUM_W'(term_abort) + SUM_W'(term_renew);

   bopc_scale #(.BASE_W(BASE_W), .SUM_W(SUM_W), .STYLE(SCALE_STYLE)) u_scale (
      .base_i (base_i),
      .sum_i  (term_sum),
      .prod_o (prod)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) period_o <= prod;
      end
   end

endmodule

// File: rtl/bopc_checker.sv
module bopc_checker #(
   parameter int  CNT_W  = 8,
   parameter int  BASE_W = 16,
   localparam int OUT_W  = BASE_W + CNT_W + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [CNT_W-1:0]  abort_cnt_i,
   input logic [CNT_W-1:0]  renew_cnt_i,
   input logic [BASE_W-1:0] base_i,
   input logic [OUT_W-1:0]  period_o,
   input logic              done_o
);

   p_done_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);

   p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);

   p_zero_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && abort_cnt_i == '0 && renew_cnt_i == '0) |=> period_o == '0);

   p_unit_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && abort_cnt_i == CNT_W'(1) && renew_cnt_i == '0)
      |=> period_o == OUT_W'($past(base_i)));

   p_power_terms_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && base_i == BASE_W'(1)) |=> $countones(period_o) <= 2);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(period_o));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> period_o <= {1'b0, $past(base_i), {(CNT_W+1){1'b0}}});

endmodule

bind backoff_period_calc bopc_checker #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .abort_cnt_i (abort_cnt_i),
   .renew_cnt_i (renew_cnt_i),
   .base_i      (base_i),
   .period_o    (period_o),
   .done_o      (done_o)
);

// File: tb/sim_backoff_period_calc.sv
module sim_backoff_period_calc;
   import bopc_pkg::*;

   localparam int CNT_W  = 8;
   localparam int BASE_W = 16;
   localparam int OUT_W  = BASE_W + CNT_W + 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [CNT_W-1:0]  abort_cnt_i = '0;
   logic [CNT_W-1:0]  renew_cnt_i = '0;
   logic [BASE_W-1:0] base_i = '0;
   logic [OUT_W-1:0]  period0, period1;
   logic              done0, done1;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   backoff_period_calc #(.CNT_W(CNT_W), .BASE_W(BASE_W),
      .TERM_STYLE(TERM_PRIO), .SCALE_STYLE(SCALE_SHIFT)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_cnt_i(abort_cnt_i),
      .renew_cnt_i(renew_cnt_i), .base_i(base_i), .period_o(period0), .done_o(done0));

   backoff_period_calc #(.CNT_W(CNT_W), .BASE_W(BASE_W),
      .TERM_STYLE(TERM_LADDER), .SCALE_STYLE(SCALE_MULT)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_cnt_i(abort_cnt_i),
      .renew_cnt_i(renew_cnt_i), .base_i(base_i), .period_o(period1), .done_o(done1));

   function automatic longint term_of(int n);
      longint p = 1;
      if (n == 0) return 0;
      while (p < n) p = p * 2;
      return p;
   endfunction

   function automatic longint expect_of(int a, int r, int b);
      return longint'(b) * (term_of(a) + term_of(r));
   endfunction

   task automatic check(string req, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic check_both(string req, longint exp);
      check(req, longint'(period0), exp);
      check(req, longint'(period1), exp);
   endtask

   // One isolated request; checks the result, the pulse end and the hold.
   task automatic one_req(string req, int a, int r, int b);
      longint exp = expect_of(a, r, b);
      @(negedge clk);
      start_i = 1'b1; abort_cnt_i = CNT_W'(a); renew_cnt_i = CNT_W'(r); base_i = BASE_W'(b);
      @(negedge clk);
      start_i = 1'b0;
      check("R1", longint'(done0 & done1), 1);
      check_both(req, exp);
      @(negedge clk);
      check("R1", longint'(done0 | done1), 0);
      check_both("R6", exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9", longint'(done0 | done1), 0);
      check_both("R9", 0);
      rst_n = 1'b1;

      one_req("R2", 0, 0, 8);
      one_req("R3", 1, 0, 8);
      one_req("R3", 0, 1, 77);
      one_req("R4", 4, 0, 1);
      one_req("R4", 5, 0, 1);
      one_req("R4", 9, 17, 3);
      one_req("R4", 128, 129, 1);
      one_req("R8", 255, 255, 65535);

      // R7: inputs move while start is low; the held period must not change.
      abort_cnt_i = 8'd3; renew_cnt_i = 8'd200; base_i = 16'd9;
      repeat (4) @(negedge clk);
      check_both("R7", expect_of(255, 255, 65535));
      check("R7", longint'(done0 | done1), 0);

      // R5: every base in a coarse sweep with fixed counts.
      for (int b = 0; b < 65536; b += 4099) one_req("R5", 6, 3, b);
      one_req("R5", 33, 2, 65535);

      // R5: every count pair at base 8, requests back to back.
      begin
         longint prev_exp = 0;
         bit have_prev = 1'b0;
         for (int a = 0; a < 256; a++) begin
            for (int r = 0; r < 256; r++) begin
               @(negedge clk);
               if (have_prev) begin
                  check("R1", longint'(done0 & done1), 1);
                  check_both("R5", prev_exp);
               end
               start_i = 1'b1; abort_cnt_i = CNT_W'(a); renew_cnt_i = CNT_W'(r); base_i = 16'd8;
               prev_exp = expect_of(a, r, 8);
               have_prev = 1'b1;
            end
         end
         @(negedge clk);
         start_i = 1'b0;
         check_both("R5", prev_exp);
         @(negedge clk);
         check("R1", longint'(done0 | done1), 0);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (120000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule